// File: doc/BRIEF.md
# Interrupt Enable and Flag Register with Two-Level Request Logic

This block is one 8-bit control and status register for interrupts, with the request logic that sits behind it. Three local event sources each have an enable bit and a flag bit: a timer overflow pulse, an external pin, and a four-pin port-change detector. A peripheral request with its own priority input joins them. Two more bits gate the whole scheme. The block drives two request lines, a high-priority one and a low-priority one, toward the processor.

A mode input decides what the two gating bits mean. In single-level mode they are a global enable and a peripheral enable, and every request comes out on the high line. In two-level mode they are a high-priority enable and a low-priority enable. The timer, pin and port sources always count as high priority. The peripheral request is sent to one line or the other by its priority input.

A flag is set by its event whether or not it is enabled, so software can poll the flags. Only a register write clears a flag. A simple write strobe with write data loads the register, and the read data always shows the current contents.

Top module: `irq_ctl_reg`

## Requirements
- R1: After reset every register bit reads 0, and both request outputs are 0.
- R2: Register bit layout: bit 7 = global/high enable, bit 6 = peripheral/low enable, bit 5 = timer enable, bit 4 = pin enable, bit 3 = port enable, bit 2 = timer flag, bit 1 = pin flag, bit 0 = port flag. A write loads bits 7..3 from the write data at the next clock edge. Without a write these bits do not change.
- R3: A one-cycle overflow pulse sets the timer flag at the next edge, whatever the state of any enable bit.
- R4: The external pin passes through two synchronizer flops, and only a rising edge sets the pin flag. A pin that goes high before edge 1 shows its flag after edge 3. A pin that stays high or falls sets nothing more.
- R5: A strobe latches a copy of the four port pins. The copy resets to 0. At the next edge, the port flag is set whenever the pins differ from the copy.
- R6: Hardware never clears a flag. A write sets each flag bit to the written value (0 clears it), and with no write a set flag stays set.
- R7: When an event and a write of 0 reach the same flag in the same cycle, the flag ends up at 1.
- R8: In single-level mode (mode input 0), the high output is 1 exactly when bit 7 is 1 and either some flag has its enable set, or bit 6 and the peripheral request are both 1. The low output is always 0.
- R9: In two-level mode (mode input 1), the high output is 1 exactly when bit 7 is 1 and either some flag has its enable set, or the peripheral request is 1 with its priority input at 1.
- R10: In two-level mode, the low output is 1 exactly when bits 7 and 6 are both 1 and the peripheral request is 1 with its priority input at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prio_mode | input | 1 | 0 = single-level mode, 1 = two-level mode |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Current register contents |
| tmr_ovf | input | 1 | Timer overflow pulse |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| port_pins | input | 4 | Watched port pins (synchronous to clk) |
| port_rd | input | 1 | Port read strobe; latches the comparison copy |
| per_req | input | 1 | Peripheral interrupt request |
| per_hi | input | 1 | Peripheral priority: 1 = high, 0 = low |
| irq_hi | output | 1 | High-priority interrupt request |
| irq_lo | output | 1 | Low-priority interrupt request |

## Verification
Some properties are checked on every cycle. Each event sets its flag at the following edge, and set flags persist without a write. An event beats a clearing write. Neither output rises without its gating bits, and the low line stays silent in single-level mode. Other behaviour shows up only in the bench's scenarios: the exact three-edge latency of the pin path, the port copy being reloaded by the strobe, and the full request equations under random mixes of mode, enables, flags and peripheral priority, all compared against the bench's own model of the register.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

  localparam int CTL_W = 8;

  typedef struct packed {
    logic gate_a;   // global enable / high-priority enable
    logic gate_b;   // peripheral enable / low-priority enable
    logic tmr_en;
    logic ext_en;
    logic pc_en;
    logic tmr_f;
    logic ext_f;
    logic pc_f;
  } ctl_t;

  function automatic logic flag_next(input logic cur, input logic wr,
                                     input logic wbit, input logic set);
    return (wr ? wbit : cur) | set;
  endfunction

  function automatic logic local_pending(input ctl_t r);
    return (r.tmr_en & r.tmr_f) | (r.ext_en & r.ext_f) | (r.pc_en & r.pc_f);
  endfunction

  function automatic logic req_hi(input ctl_t r, input logic prio,
                                  input logic preq, input logic phi);
    logic per_part;
    per_part = prio ? (preq & phi) : (preq & r.gate_b);
    return r.gate_a & (local_pending(r) | per_part);
  endfunction

  function automatic logic req_lo(input ctl_t r, input logic prio,
                                  input logic preq, input logic phi);
    return prio & r.gate_a & r.gate_b & preq & ~phi;
  endfunction

endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);
  localparam int DW = STAGES + 1;

  logic [DW-1:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[DW-2:0], pin_i};
  end

  assign rise_o = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/irq_port_watch.sv
module irq_port_watch #(
  parameter int NPINS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins_i,
  input  logic             rd_i,
  output logic             changed_o
);
  logic [NPINS-1:0] copy_q;
  logic [NPINS-1:0] diff;

  always_ff @(posedge clk) begin
    if (!rst_n)    copy_q <= '0;
    else if (rd_i) copy_q <= pins_i;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NPINS; gi++) begin : g_cmp
      assign diff[gi] = pins_i[gi] ^ copy_q[gi];
    end
  endgenerate

  assign changed_o = |diff;
endmodule

// File: rtl/irq_req_logic.sv
module irq_req_logic
  import irq_ctl_pkg::*;
(
  input  ctl_t ctl_i,
  input  logic prio_i,
  input  logic preq_i,
  input  logic phi_i,
  output logic hi_o,
  output logic lo_o
);
  always_comb begin
    hi_o = req_hi(ctl_i, prio_i, preq_i, phi_i);
    lo_o = req_lo(ctl_i, prio_i, preq_i, phi_i);
  end
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
  import irq_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PORT_PINS   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 prio_mode,
  input  logic                 bus_wr,
  input  logic [CTL_W-1:0]     bus_wdata,
  output logic [CTL_W-1:0]     bus_rdata,
  input  logic                 tmr_ovf,
  input  logic                 ext_pin,
  input  logic [PORT_PINS-1:0] port_pins,
  input  logic                 port_rd,
  input  logic                 per_req,
  input  logic                 per_hi,
  output logic                 irq_hi,
  output logic                 irq_lo
);
  localparam int NFLAGS = 3;

  ctl_t ctl_q, ctl_d, wr_view;

  // named internal events
  logic ev_tmr, ev_ext, ev_pc;
  logic [NFLAGS-1:0] ev_vec, flag_cur, flag_wr, flag_nxt;

  assign ev_tmr = tmr_ovf;

  irq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_pin), .rise_o(ev_ext)
  );

  irq_port_watch #(.NPINS(PORT_PINS)) u_watch (
    .clk(clk), .rst_n(rst_n), .pins_i(port_pins), .rd_i(port_rd),
    .changed_o(ev_pc)
  );

  assign wr_view  = ctl_t'(bus_wdata);
  assign ev_vec   = {ev_tmr, ev_ext, ev_pc};
  assign flag_cur = {ctl_q.tmr_f, ctl_q.ext_f, ctl_q.pc_f};
  assign flag_wr  = {wr_view.tmr_f, wr_view.ext_f, wr_view.pc_f};

  genvar fi;
  generate
    for (fi = 0; fi < NFLAGS; fi++) begin : g_flag
      assign flag_nxt[fi] = flag_next(flag_cur[fi], bus_wr, flag_wr[fi], ev_vec[fi]);
    end
  endgenerate

  always_comb begin
    ctl_d = ctl_q;
    if (bus_wr) begin
      ctl_d.gate_a = wr_view.gate_a;
      ctl_d.gate_b = wr_view.gate_b;
      ctl_d.tmr_en = wr_view.tmr_en;
      ctl_d.ext_en = wr_view.ext_en;
      ctl_d.pc_en  = wr_view.pc_en;
    end
    ctl_d.tmr_f = flag_nxt[2];
    ctl_d.ext_f = flag_nxt[1];
    ctl_d.pc_f  = flag_nxt[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assign bus_rdata = ctl_q;

  irq_req_logic u_req (
    .ctl_i(ctl_q), .prio_i(prio_mode), .preq_i(per_req), .phi_i(per_hi),
    .hi_o(irq_hi), .lo_o(irq_lo)
  );
endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       prio_mode,
  input logic       bus_wr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       tmr_ovf,
  input logic       per_req,
  input logic       per_hi,
  input logic       ev_ext,
  input logic       ev_pc,
  input logic       irq_hi,
  input logic       irq_lo
);
  // R2
  en_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(bus_rdata[7:3]));

  // R3
  tmr_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> bus_rdata[2]);

  // R4
  ext_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ext |=> bus_rdata[1]);

  // R5
  pc_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pc |=> bus_rdata[0]);

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ((bus_rdata[2:0] & $past(bus_rdata[2:0])) == $past(bus_rdata[2:0])));

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_wdata[2] && tmr_ovf) |=> bus_rdata[2]);

  // R8
  single_lo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prio_mode |-> !irq_lo);

  // R9
  hi_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi |-> bus_rdata[7]);

  // R10
  lo_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo |-> (bus_rdata[7] && bus_rdata[6] && per_req && !per_hi));
endmodule

bind irq_ctl_reg irq_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .prio_mode(prio_mode), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_ovf(tmr_ovf),
  .per_req(per_req), .per_hi(per_hi), .ev_ext(ev_ext), .ev_pc(ev_pc),
  .irq_hi(irq_hi), .irq_lo(irq_lo)
);

// File: tb/irq_ctl_reg_tb.sv
module irq_ctl_reg_tb;
  logic clk = 0, rst_n = 0;
  logic prio_mode = 0, bus_wr = 0, tmr_ovf = 0, ext_pin = 0, port_rd = 0;
  logic per_req = 0, per_hi = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [3:0] port_pins = 0;
  logic irq_hi, irq_lo;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  // bench model state
  logic [7:0] m_reg = 0;
  logic [3:0] m_copy = 0;
  logic s1 = 0, s2 = 0, s3 = 0;

  always #4 clk = ~clk;

  irq_ctl_reg u_dut (
    .clk(clk), .rst_n(rst_n), .prio_mode(prio_mode), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_ovf(tmr_ovf),
    .ext_pin(ext_pin), .port_pins(port_pins), .port_rd(port_rd),
    .per_req(per_req), .per_hi(per_hi), .irq_hi(irq_hi), .irq_lo(irq_lo)
  );

  function automatic logic any_enabled(input logic [7:0] r);
    return |(r[5:3] & r[2:0]);
  endfunction

  function automatic logic exp_hi(input logic [7:0] r, input logic pm,
                                  input logic rq, input logic hi);
    if (!r[7]) return 1'b0;
    if (any_enabled(r)) return 1'b1;
    return pm ? (rq && hi) : (rq && r[6]);
  endfunction

  function automatic logic exp_lo(input logic [7:0] r, input logic pm,
                                  input logic rq, input logic hi);
    return pm && r[7] && r[6] && rq && !hi;
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(bus_rdata[7:3] == m_reg[7:3], "R2 enables", bus_rdata[7:3], m_reg[7:3]);
    chk(bus_rdata[2] == m_reg[2], "R3 timer flag", bus_rdata[2], m_reg[2]);
    chk(bus_rdata[1] == m_reg[1], "R4 pin flag", bus_rdata[1], m_reg[1]);
    chk(bus_rdata[0] == m_reg[0], "R5 port flag", bus_rdata[0], m_reg[0]);
    if (prio_mode) begin
      chk(irq_hi == exp_hi(m_reg, 1, per_req, per_hi), "R9 hi", irq_hi,
          exp_hi(m_reg, 1, per_req, per_hi));
      chk(irq_lo == exp_lo(m_reg, 1, per_req, per_hi), "R10 lo", irq_lo,
          exp_lo(m_reg, 1, per_req, per_hi));
    end else begin
      chk(irq_hi == exp_hi(m_reg, 0, per_req, per_hi), "R8 hi", irq_hi,
          exp_hi(m_reg, 0, per_req, per_hi));
      chk(irq_lo == 1'b0, "R8 lo", irq_lo, 0);
    end
  endtask

  // one clock: inputs applied now (at negedge), model advanced, compared next negedge
  task automatic step(input logic wr, input logic [7:0] wd, input logic tov,
                      input logic pin, input logic [3:0] pins, input logic prd,
                      input logic rq, input logic hi, input logic pm);
    logic [7:0] nx;
    logic [2:0] sets;
    bus_wr = wr; bus_wdata = wd; tmr_ovf = tov; ext_pin = pin;
    port_pins = pins; port_rd = prd; per_req = rq; per_hi = hi; prio_mode = pm;
    sets = {tov, s2 & ~s3, pins != m_copy};
    nx[7:3] = wr ? wd[7:3] : m_reg[7:3];
    for (int i = 0; i < 3; i++) nx[i] = (wr ? wd[i] : m_reg[i]) | sets[i];
    @(posedge clk);
    s3 = s2; s2 = s1; s1 = pin;
    if (prd) m_copy = pins;
    m_reg = nx;
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++)
      step(0, 0, 0, ext_pin, port_pins, 0, per_req, per_hi, prio_mode);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(bus_rdata == 8'h00, "R1 reset reg", bus_rdata, 0);
    chk(irq_hi == 0 && irq_lo == 0, "R1 reset outs", {irq_hi, irq_lo}, 0);
    rst_n = 1;
    @(negedge clk);
    compare_all();

    // R4: pin high before edge 1, flag after edge 3
    step(0, 0, 0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0, 0, 0);
    chk(bus_rdata[1] == 0, "R4 not before third edge", bus_rdata[1], 0);
    step(0, 0, 0, 1, 0, 0, 0, 0, 0);
    chk(bus_rdata[1] == 1, "R4 set at third edge", bus_rdata[1], 1);
    step(1, 8'h00, 0, 1, 0, 0, 0, 0, 0);
    idle(4);
    chk(bus_rdata[1] == 0, "R4 steady high sets nothing", bus_rdata[1], 0);

    // R3 with all enables off
    step(0, 0, 1, 1, 0, 0, 0, 0, 0);
    chk(bus_rdata[2] == 1, "R3 flag without enable", bus_rdata[2], 1);
    // R6 persistence
    idle(5);
    chk(bus_rdata[2] == 1, "R6 flag persists", bus_rdata[2], 1);
    // R7 set beats clear
    step(1, 8'h00, 1, 1, 0, 0, 0, 0, 0);
    chk(bus_rdata[2] == 1, "R7 set wins", bus_rdata[2], 1);
    step(1, 8'h00, 0, 1, 0, 0, 0, 0, 0);
    chk(bus_rdata[2] == 0, "R6 write clears", bus_rdata[2], 0);

    // R5 port change then re-latch
    step(0, 0, 0, 1, 4'h5, 1, 0, 0, 0);
    chk(bus_rdata[0] == 1, "R5 change sets flag", bus_rdata[0], 1);
    step(1, 8'h00, 0, 1, 4'h5, 0, 0, 0, 0);
    idle(2);
    chk(bus_rdata[0] == 0, "R5 matched copy quiet", bus_rdata[0], 0);

    // R10 directed low request
    step(1, 8'hC0, 0, 1, 4'h5, 0, 1, 0, 1);
    chk(irq_lo == 1 && irq_hi == 0, "R10 low only", {irq_hi, irq_lo}, 1);

    // random mix
    for (int k = 0; k < 4000; k++) begin
      logic wr, tov, pin, prd, rq, hi, pm;
      logic [3:0] pins;
      logic [7:0] wd;
      wr   = ($urandom % 6) == 0;
      wd   = 8'($urandom);
      tov  = ($urandom % 12) == 0;
      pin  = (($urandom % 7) == 0) ? ~ext_pin : ext_pin;
      pins = (($urandom % 10) == 0) ? 4'($urandom) : port_pins;
      prd  = ($urandom % 5) == 0;
      rq   = $urandom % 2;
      hi   = $urandom % 2;
      pm   = (($urandom % 50) == 0) ? ~prio_mode : prio_mode;
      step(wr, wd, tov, pin, pins, prd, rq, hi, pm);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule